// File: doc/BRIEF.md
# Memory Request Coalescer

This block sits between a group of sixteen parallel lanes and the memory port. It accepts one gathered request at a time. The request carries one byte address per lane, an active-lane mask, an element width and a rule-set bit. The block then works out the fewest memory transactions that the selected rule set allows. It issues them one per handshake on an output stream. Each transaction carries an aligned base address, a length in bytes and the set of lanes it serves. A one-cycle completion pulse follows the last transaction. The block decides only the shape of the traffic. It does not move data or generate addresses.

Two rule sets are available:

- **Strict rule set.** A single wide transaction is issued only for a perfectly sequential, span-aligned, fully active pattern. Anything else falls back to sixteen serialized per-lane slots.
- **Relaxed rule set.** Active lanes are grouped by the aligned segment they land in. The segment size depends on the element width. One transaction is issued per segment touched, lowest segment first.

Top module: `mem_coalescer`

## Requirements
- R1: `req_ready` is high only while the block is idle. While it is high, no transaction is offered and `done` is low. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A request held pending during a run is taken only in the cycle after `done`.
- R2: `req_esz` selects the element size: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. In the strict rule set, a coalesced transaction has length 16 times the element size. A per-lane transaction has length equal to the element size.
- R3: When `req_relaxed` is 0, a request is coalesced into one transaction only when all three conditions hold:
  - all 16 lanes are active;
  - lane k addresses lane 0's address plus k times the element size;
  - lane 0's address is a multiple of 16 times the element size.

  That transaction has base equal to lane 0's address and lane set 0xFFFF.
- R4: When `req_relaxed` is 0 and the R3 condition fails, the block steps through 16 slots in lane order (lane 0 first), one slot per cycle.
  - An active lane's slot offers a transaction and holds until it is accepted. The transaction has base equal to the lane address rounded down to the element size, and lane set 1<<k.
  - An inactive lane's slot offers nothing and lasts exactly one cycle.
- R5: When `req_relaxed` is 1, the segment size is 32 bytes for 1-byte elements, 64 bytes for 2-byte elements, and 128 bytes for 4-byte or 8-byte elements. Each transaction's base is segment-aligned and its length is the segment size.
- R6: When `req_relaxed` is 1, exactly one transaction is issued for each distinct segment that holds at least one active lane's address. The order of addresses across lanes does not matter. The transaction's lane set is exactly the active lanes in that segment. Transactions go out in ascending segment address.
- R7: In the relaxed rule set, a sequential pattern that starts misaligned and crosses one segment boundary produces exactly two transactions.
- R8: A request with an all-zero mask produces no transaction in either rule set. `done` is high in the cycle right after the request is taken.
- R9: While `txn_valid` is high and `txn_ready` is low, the offered base, length and lane set stay unchanged into the next cycle.
- R10: `done` is high for exactly one cycle. That cycle directly follows the edge that accepted the request's last transaction or ended its last strict slot.
- R11: In the relaxed rule set, the addresses of inactive lanes have no effect on the transactions produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | LANES*AW | Per-lane byte addresses, lane k at bits k*AW upward |
| req_mask | input | LANES | Active-lane mask, bit k for lane k |
| req_esz | input | 2 | Element size code (R2) |
| req_relaxed | input | 1 | 1 selects the relaxed rule set, 0 the strict one |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Memory side takes the offered transaction |
| txn_base | output | AW | Aligned base byte address |
| txn_bytes | output | log2(LANES)+4 | Transaction length in bytes |
| txn_lanes | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block at its defaults: 16 lanes and 32-bit addresses. At these values each strict coalesced span and each relaxed segment is at most 128 bytes. The segment-crossing, permuted and scattered patterns can therefore be placed at small hand-picked addresses, and every expected lane set fits in one 16-bit word. The wide address also lets a descending scatter spread across sixteen separate segments, which exercises the full ascending-order sort. Every pattern is then run again under random output backpressure.

// File: rtl/mem_coalescer.sv
module mem_coalescer #(
  parameter int LANES = 16,
  parameter int AW = 32,
  localparam int LW = $clog2(LANES),
  localparam int BW = LW + 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [LANES*AW-1:0]   req_addr,
  input  logic [LANES-1:0]      req_mask,
  input  logic [1:0]            req_esz,
  input  logic                  req_relaxed,
  output logic                  txn_valid,
  input  logic                  txn_ready,
  output logic [AW-1:0]         txn_base,
  output logic [BW-1:0]         txn_bytes,
  output logic [LANES-1:0]      txn_lanes,
  output logic                  done
);

  localparam int SEG0 = 5;

  typedef enum logic [1:0] {IDLE, BUSY, FIN} st_t;

  st_t              st;
  logic [AW-1:0]    a_r [LANES];
  logic [LANES-1:0] m_r, pend, sel;
  logic [1:0]       esz_r;
  logic             rlx_r;
  logic [LW-1:0]    slot;
  logic             strict_ok, found;
  logic [2:0]       seg_lg;
  logic [AW-1:0]    span_msk, minseg;

  assign req_ready = (st == IDLE);
  assign done      = (st == FIN);
  assign seg_lg    = 3'(SEG0) + ((esz_r > 2'd2) ? 3'd2 : {1'b0, esz_r});
  assign span_msk  = (AW'(1) << (LW + int'(esz_r))) - AW'(1);

  always_comb begin
    strict_ok = (&m_r) && ((a_r[0] & span_msk) == '0);
    for (int k = 1; k < LANES; k++)
      if (a_r[k] != a_r[0] + (AW'(k) << esz_r)) strict_ok = 1'b0;
  end

  always_comb begin
    found  = 1'b0;
    minseg = '0;
    for (int k = 0; k < LANES; k++)
      if (pend[k] && (!found || (a_r[k] >> seg_lg) < minseg)) begin
        found  = 1'b1;
        minseg = a_r[k] >> seg_lg;
      end
    for (int k = 0; k < LANES; k++)
      sel[k] = pend[k] && ((a_r[k] >> seg_lg) == minseg);
  end

  always_comb begin
    txn_valid = 1'b0;
    txn_base  = '0;
    txn_bytes = '0;
    txn_lanes = '0;
    if (st == BUSY) begin
      if (rlx_r) begin
        txn_valid = found;
        txn_base  = minseg << seg_lg;
        txn_bytes = BW'(1) << seg_lg;
        txn_lanes = sel;
      end else if (strict_ok) begin
        txn_valid = 1'b1;
        txn_base  = a_r[0];
        txn_bytes = BW'(1) << (LW + int'(esz_r));
        txn_lanes = m_r;
      end else begin
        txn_valid = m_r[slot];
        txn_base  = a_r[slot] & ~((AW'(1) << esz_r) - AW'(1));
        txn_bytes = BW'(1) << esz_r;
        txn_lanes = m_r[slot] ? (LANES'(1) << slot) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      m_r   <= '0;
      pend  <= '0;
      esz_r <= '0;
      rlx_r <= 1'b0;
      slot  <= '0;
      for (int k = 0; k < LANES; k++) a_r[k] <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          for (int k = 0; k < LANES; k++) a_r[k] <= req_addr[k*AW +: AW];
          m_r   <= req_mask;
          pend  <= req_mask;
          esz_r <= req_esz;
          rlx_r <= req_relaxed;
          slot  <= '0;
          st    <= (|req_mask) ? BUSY : FIN;
        end
        BUSY: begin
          if (rlx_r) begin
            if (txn_ready) begin
              pend <= pend & ~sel;
              if ((pend & ~sel) == '0) st <= FIN;
            end
          end else if (strict_ok) begin
            if (txn_ready) st <= FIN;
          end else if (!m_r[slot] || txn_ready) begin
            slot <= slot + LW'(1);
            if (slot == LW'(LANES - 1)) st <= FIN;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!txn_valid && !done));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) &&
                                   $stable(txn_bytes) && $stable(txn_lanes)));

  // R6
  lane_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (((txn_lanes & ~m_r) == '0) && (txn_lanes != '0)));

  // R4
  per_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !rlx_r && (txn_lanes != m_r)) |-> ($countones(txn_lanes) == 1));

  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_mask == '0)) |=> done);

endmodule

// File: tb/tb_mem_coalescer.sv
module tb_mem_coalescer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_relaxed = 1'b0, txn_valid, txn_ready = 1'b1, done;
  logic [511:0] req_addr = '0;
  logic [15:0] req_mask = '0, txn_lanes;
  logic [1:0] req_esz = '0;
  logic [31:0] txn_base;
  logic [7:0] txn_bytes;

  always #4 clk = ~clk;

  mem_coalescer dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .req_esz(req_esz), .req_relaxed(req_relaxed),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base), .txn_bytes(txn_bytes),
    .txn_lanes(txn_lanes), .done(done));

  typedef struct packed { logic v; logic [31:0] base; logic [7:0] bytes; logic [15:0] lanes; } item_t;
  typedef struct packed { logic [511:0] addr; logic [15:0] mask; logic [1:0] esz; logic rlx; } req_t;

  item_t q[$];
  req_t reqs[$];
  string rtags[$];
  string cur_tag;
  int nchk = 0, nerr = 0, cycles = 0, mst = 0;
  bit bp = 0, held = 0, zero_req = 0, timeout = 0, cur_rlx = 0;

  function automatic void chk(bit ok, string tag, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endfunction

  function automatic logic [511:0] seq(int base, int es);
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[k*32 +: 32] = 32'(base + k*es);
    return r;
  endfunction

  function automatic void build(req_t r);
    int es = 1 << r.esz;
    int a[16];
    q.delete();
    for (int k = 0; k < 16; k++) a[k] = int'(r.addr[k*32 +: 32]);
    if (r.mask == 0) return;
    if (!r.rlx) begin
      bit ok = (r.mask == 16'hFFFF) && (a[0] % (16*es) == 0);
      for (int k = 0; k < 16; k++) if (a[k] != a[0] + k*es) ok = 0;
      if (ok) q.push_back({1'b1, 32'(a[0]), 8'(16*es), 16'hFFFF});
      else
        for (int k = 0; k < 16; k++)
          q.push_back({r.mask[k], 32'(a[k] - a[k] % es), 8'(es), r.mask[k] ? 16'(1 << k) : 16'h0});
    end else begin
      int seg = (r.esz == 0) ? 32 : (r.esz == 1) ? 64 : 128;
      int segs[$];
      for (int k = 0; k < 16; k++)
        if (r.mask[k]) begin
          int s = a[k] - a[k] % seg;
          bit seen = 0;
          foreach (segs[i]) if (segs[i] == s) seen = 1;
          if (!seen) segs.push_back(s);
        end
      for (int i = 1; i < segs.size(); i++)
        for (int j = i; j > 0 && segs[j-1] > segs[j]; j--) begin
          int t = segs[j]; segs[j] = segs[j-1]; segs[j-1] = t;
        end
      foreach (segs[i]) begin
        logic [15:0] m = '0;
        for (int k = 0; k < 16; k++) if (r.mask[k] && (a[k] - a[k] % seg == segs[i])) m[k] = 1'b1;
        q.push_back({1'b1, 32'(segs[i]), 8'(seg), m});
      end
    end
  endfunction

  task automatic tick();
    bit rdy;
    @(negedge clk);
    cycles++;
    if (reqs.size() > 0) begin
      req_valid = 1'b1; req_addr = reqs[0].addr; req_mask = reqs[0].mask;
      req_esz = reqs[0].esz; req_relaxed = reqs[0].rlx;
    end else begin
      req_valid = 1'b0; req_addr = {16{32'hDEAD_BEE0}}; req_mask = 16'h1234;
    end
    rdy = bp ? ($urandom % 3 != 0) : 1'b1;
    txn_ready = rdy;
    #1;
    case (mst)
      0: begin
        chk(req_ready == 1'b1, "R1", "req_ready idle", req_ready, 1);
        chk(txn_valid == 1'b0, "R1", "txn_valid idle", txn_valid, 0);
        chk(done == 1'b0, "R10", "done idle", done, 0);
        if (req_valid) begin
          build(reqs[0]);
          zero_req = (reqs[0].mask == 0);
          cur_rlx = reqs[0].rlx;
          cur_tag = rtags[0];
          void'(reqs.pop_front());
          void'(rtags.pop_front());
          held = 0;
          mst = (q.size() > 0) ? 1 : 2;
        end
      end
      1: begin
        string t = held ? "R9" : cur_tag;
        chk(req_ready == 1'b0, "R1", "req_ready busy", req_ready, 0);
        chk(done == 1'b0, "R10", "done busy", done, 0);
        chk(txn_valid == q[0].v, t, "txn_valid", txn_valid, q[0].v);
        if (q[0].v) begin
          chk(txn_base == q[0].base, t, "txn_base", txn_base, q[0].base);
          chk(txn_bytes == q[0].bytes, cur_rlx ? "R5" : "R2", "txn_bytes", txn_bytes, q[0].bytes);
          chk(txn_lanes == q[0].lanes, t, "txn_lanes", txn_lanes, q[0].lanes);
        end
        held = q[0].v && !rdy;
        if (!q[0].v || rdy) void'(q.pop_front());
        if (q.size() == 0) mst = 2;
      end
      default: begin
        chk(done == 1'b1, zero_req ? "R8" : "R10", "done", done, 1);
        chk(txn_valid == 1'b0, "R10", "txn_valid at done", txn_valid, 0);
        chk(req_ready == 1'b0, "R1", "req_ready at done", req_ready, 0);
        mst = 0;
      end
    endcase
  endtask

  task automatic add(logic [511:0] a, logic [15:0] m, logic [1:0] e, bit rlx, string tag);
    reqs.push_back({a, m, e, rlx});
    rtags.push_back(tag);
  endtask

  task automatic load_all();
    logic [511:0] p, s;
    add(seq(32'h100, 4), 16'hFFFF, 2'd2, 0, "R3");
    add(seq(32'h40, 1), 16'hFFFF, 2'd0, 0, "R3");
    add(seq(32'h80, 8), 16'hFFFF, 2'd3, 0, "R3");
    add(seq(32'h104, 4), 16'hFFFF, 2'd2, 0, "R4");
    for (int k = 0; k < 16; k++) p[k*32 +: 32] = 32'h200 + 32'(((k*7) % 16) * 4);
    add(p, 16'hFFFF, 2'd2, 0, "R4");
    add(seq(32'h300, 4), 16'h7FFF, 2'd2, 0, "R4");
    s = seq(32'h340, 2);
    s[5*32 +: 32] = 32'h390;
    add(s, 16'hFFFF, 2'd1, 0, "R4");
    for (int k = 0; k < 16; k++) p[k*32 +: 32] = 32'h400 + 32'(((k*7) % 16) * 4);
    add(p, 16'hFFFF, 2'd2, 1, "R6");
    add(seq(32'h560, 4), 16'hFFFF, 2'd2, 1, "R7");
    add(seq(32'h610, 1), 16'hFFFF, 2'd0, 1, "R5");
    add(seq(32'h720, 2), 16'hFFFF, 2'd1, 1, "R5");
    add(seq(32'h840, 8), 16'hFFFF, 2'd3, 1, "R7");
    for (int k = 0; k < 16; k++) p[k*32 +: 32] = 32'h10000 - 32'(k * 32'h100);
    add(p, 16'hFFFF, 2'd2, 1, "R6");
    s = seq(32'h900, 4);
    for (int k = 0; k < 16; k++) if (k < 4 || k > 7) s[k*32 +: 32] = 32'h7000 + 32'(k * 32'h333);
    add(s, 16'h00F0, 2'd2, 1, "R11");
    add(seq(32'h100, 4), 16'h0000, 2'd2, 0, "R8");
    add(seq(32'h100, 4), 16'h0000, 2'd2, 1, "R8");
    add(seq(32'hA0C, 4), 16'h8421, 2'd2, 1, "R6");
  endtask

  task automatic drain();
    while ((reqs.size() > 0 || mst != 0) && !timeout) begin
      tick();
      if (cycles > 50000) timeout = 1;
    end
    repeat (3) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0 || txn_valid == 1'b0, "R1", "reset txn_valid", txn_valid, 0);
    rst_n = 1'b1;
    load_all();
    bp = 0;
    drain();
    load_all();
    bp = 1;
    drain();
    if (timeout) begin
      nchk++; nerr++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", cycles, 50000);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule